// File: doc/BRIEF.md
# ADC Conversion Sequencer with Averaging

This block sits between a simple register bus and an eight-input, 10-bit sampling front end. Software programs a converter clock divider, then writes one command word. That word enables the converter, picks an input, sets how many samples to average, chooses the reference and launches a conversion. The block derives the converter clock from the bus clock. It requests each sample on a rising converter-clock edge and waits for the front end's valid strobe. It adds up the returned codes and divides the total by a power of two. It then stores the result and raises a level interrupt. Reading the result clears the interrupt.

The front end is modelled as a handshake: a one-cycle request carrying the channel, answered later by a one-cycle valid strobe with the code. Eight general per-channel control words are kept for software. Eight per-channel data registers each hold the most recent result for their input. A command write of zero disables the converter, stops the clock and abandons any sequence in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the interrupt, converter clock and sample request are low, and the command (address 0), divider (address 1) and result (address 2) registers read zero.
- R2: A command write with bit 0 (start) and bit 4 (enable) set, made while no sequence runs, launches a sequence on the input given by bits 3:1. The front end sees that channel on every request. Bit 9 drives the reference-select output.
- R3: While enabled, the converter clock stays low for the count in divider bits 3:0 and high for the count in bits 7:4, both in bus clocks. While disabled it stays low.
- R4: A phase count of zero behaves as a count of one.
- R5: An averaging field (command bits 8:5) of zero takes exactly one sample, and the result equals that code.
- R6: An averaging field N>0 takes exactly 2^N samples, and the result is their sum shifted right by N.
- R7: The result reads in bits 9:0 of address 2 with the upper bits zero. The same value reads from the data register at address 16 plus the channel.
- R8: The interrupt goes high when a result is stored and stays high until address 2 is read; that read clears it.
- R9: A start is ignored while the enable bit is clear or while a sequence runs. An ignored start issues no extra requests and does not change the running channel.
- R10: The start bit reads back as zero; the other command fields read back as written.
- R11: Each sample request lasts one cycle and falls in the first cycle the converter clock is high.
- R12: Writing zero to the command register aborts a running sequence without an interrupt and holds the clock low. The per-channel control registers at addresses 8 to 15 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| adc_clk | output | 1 | Generated converter clock |
| fe_req | output | 1 | One-cycle sample request |
| fe_chan | output | 3 | Channel of the running sequence |
| fe_vref_int | output | 1 | Internal reference select |
| fe_valid | input | 1 | Sample valid strobe from front end |
| fe_code | input | 10 | Sample code |
| irq | output | 1 | Conversion-done interrupt level |

## Verification
The assertions assume that the front end raises its valid strobe only after a request and at most once per request. They also assume that a result is stored only on the cycle after an accepted sample. The bench's front-end model keeps to this. It waits for each request and answers after a random delay of zero to three cycles with one strobe. The bus never reads and writes in the same cycle. Random runs keep the averaging field at three or below so that sequences stay short. Aborts, ignored starts and zero phase counts are driven as directed cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CODE_W = 10;
    localparam int N_CH   = 8;
    localparam int CH_W   = $clog2(N_CH);
    localparam int AVG_W  = 4;
    localparam int PH_W   = 4;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam int MAX_LOG = (1 << AVG_W) - 1;
    localparam int ACC_W   = CODE_W + MAX_LOG;
    localparam int CNT_W   = MAX_LOG + 1;
    localparam int CMD_W   = 1 + AVG_W + 1 + CH_W + 1;
    localparam int DIV_W   = 2 * PH_W;

    localparam logic [ADDR_W-1:0] A_CMD      = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIV      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RES      = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CTL      = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_CTL_LAST = ADDR_W'(8 + N_CH - 1);
    localparam logic [ADDR_W-1:0] A_DAT      = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_DAT_LAST = ADDR_W'(16 + N_CH - 1);

    // Field order matches the command word bit positions (MSB first).
    typedef struct packed {
        logic              int_ref;
        logic [AVG_W-1:0]  avg_log;
        logic              enable;
        logic [CH_W-1:0]   chan;
        logic              start;
    } cmd_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EDGE = 2'd1,
        S_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic [CODE_W-1:0] value;
    } result_t;

    function automatic logic [PH_W-1:0] phase_len(input logic [PH_W-1:0] c);
        return (c == '0) ? PH_W'(1) : c;
    endfunction

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
    import adc_seq_pkg::*;
#(
    parameter int P_W = PH_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [P_W-1:0] lo_cnt,
    input  logic [P_W-1:0] hi_cnt,
    output logic           adc_clk,
    output logic           rise_next
);

    logic           ph_q;
    logic [P_W-1:0] cnt_q;
    logic [P_W-1:0] lo_len;
    logic [P_W-1:0] hi_len;
    logic [P_W-1:0] cur_len;

    always_comb begin
        lo_len  = (lo_cnt == '0) ? P_W'(1) : lo_cnt;
        hi_len  = (hi_cnt == '0) ? P_W'(1) : hi_cnt;
        cur_len = ph_q ? hi_len : lo_len;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (cnt_q >= cur_len - P_W'(1)) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + P_W'(1);
        end
    end

    assign adc_clk   = ph_q;
    assign rise_next = en && !ph_q && (cnt_q >= lo_len - P_W'(1));

    p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> !adc_clk);

    p_rise_follows_r11: assert property (@(posedge clk) disable iff (rst)
        rise_next |=> adc_clk);

endmodule

// File: rtl/adc_avg_engine.sv
module adc_avg_engine
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              launch,
    input  logic [CH_W-1:0]   chan_in,
    input  logic [AVG_W-1:0]  avg_in,
    input  logic              edge_rise,
    input  logic              adc_clk,
    input  logic              fe_valid,
    input  logic [CODE_W-1:0] fe_code,
    output logic              fe_req,
    output logic [CH_W-1:0]   cur_chan,
    output logic              busy,
    output logic              store,
    output result_t           result
);

    seq_state_e        state_q;
    logic [CH_W-1:0]   chan_q;
    logic [AVG_W-1:0]  n_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ACC_W-1:0]  acc_q;
    logic              req_q;
    logic              store_q;
    logic [CODE_W-1:0] res_q;
    logic [ACC_W-1:0]  acc_sum;
    logic              last_sample;

    always_comb begin
        acc_sum     = acc_q + {{(ACC_W-CODE_W){1'b0}}, fe_code};
        last_sample = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            chan_q  <= '0;
            n_q     <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            req_q   <= 1'b0;
            store_q <= 1'b0;
            res_q   <= '0;
        end else begin
            req_q   <= 1'b0;
            store_q <= 1'b0;
            if (launch) begin
                state_q <= S_EDGE;
                chan_q  <= chan_in;
                n_q     <= avg_in;
                cnt_q   <= CNT_W'(1) << avg_in;
                acc_q   <= '0;
            end else if (!en) begin
                state_q <= S_IDLE;
            end else begin
                case (state_q)
                    S_EDGE: begin
                        if (edge_rise) begin
                            req_q   <= 1'b1;
                            state_q <= S_WAIT;
                        end
                    end
                    S_WAIT: begin
                        if (fe_valid) begin
                            acc_q <= acc_sum;
                            if (last_sample) begin
                                store_q <= 1'b1;
                                res_q   <= CODE_W'(acc_sum >> n_q);
                                state_q <= S_IDLE;
                            end else begin
                                cnt_q   <= cnt_q - CNT_W'(1);
                                state_q <= S_EDGE;
                            end
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign fe_req       = req_q;
    assign cur_chan     = chan_q;
    assign busy         = (state_q != S_IDLE);
    assign store        = store_q;
    assign result.chan  = chan_q;
    assign result.value = res_q;

    p_req_single_r11: assert property (@(posedge clk) disable iff (rst)
        fe_req |=> !fe_req);

    p_req_on_rise_r11: assert property (@(posedge clk) disable iff (rst)
        fe_req |-> (adc_clk && !$past(adc_clk)));

    p_store_after_sample_r8: assert property (@(posedge clk) disable iff (rst)
        store |-> $past(fe_valid));

    p_launch_idle_r9: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

endmodule

// File: rtl/adc_regs.sv
module adc_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              store,
    input  result_t           result,
    output cmd_t              cmd,
    output logic [PH_W-1:0]   lo_cnt,
    output logic [PH_W-1:0]   hi_cnt,
    output logic              launch,
    output logic              irq
);

    cmd_t              cmd_q;
    cmd_t              new_cmd;
    logic [DIV_W-1:0]  div_q;
    logic [CODE_W-1:0] res_q;
    logic              irq_q;
    logic [DATA_W-1:0] ctl_q [N_CH];
    logic [CODE_W-1:0] dat_q [N_CH];

    logic              wr_cmd;
    logic              rd_res;
    logic              in_ctl;
    logic              in_dat;
    logic [CH_W-1:0]   ctl_idx;
    logic [CH_W-1:0]   dat_idx;

    always_comb begin
        wr_cmd  = bus_wr && (bus_addr == A_CMD);
        rd_res  = bus_rd && (bus_addr == A_RES);
        new_cmd = cmd_t'(bus_wdata[CMD_W-1:0]);
        launch  = wr_cmd && new_cmd.start && new_cmd.enable && !busy;
        in_ctl  = (bus_addr >= A_CTL) && (bus_addr <= A_CTL_LAST);
        in_dat  = (bus_addr >= A_DAT) && (bus_addr <= A_DAT_LAST);
        ctl_idx = CH_W'(bus_addr - A_CTL);
        dat_idx = CH_W'(bus_addr - A_DAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            div_q <= '0;
            res_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wr_cmd) begin
                cmd_q       <= new_cmd;
                cmd_q.start <= 1'b0;
            end
            if (bus_wr && (bus_addr == A_DIV)) begin
                div_q <= bus_wdata[DIV_W-1:0];
            end
            if (store) begin
                res_q <= result.value;
                irq_q <= 1'b1;
            end else if (rd_res) begin
                irq_q <= 1'b0;
            end
        end
    end

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[gi] <= '0;
                dat_q[gi] <= '0;
            end else begin
                if (bus_wr && (bus_addr == ADDR_W'(A_CTL + ADDR_W'(gi)))) begin
                    ctl_q[gi] <= bus_wdata;
                end
                if (store && (result.chan == CH_W'(gi))) begin
                    dat_q[gi] <= result.value;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD) begin
            bus_rdata[CMD_W-1:0] = cmd_q;
        end else if (bus_addr == A_DIV) begin
            bus_rdata[DIV_W-1:0] = div_q;
        end else if (bus_addr == A_RES) begin
            bus_rdata[CODE_W-1:0] = res_q;
        end else if (in_ctl) begin
            bus_rdata = ctl_q[ctl_idx];
        end else if (in_dat) begin
            bus_rdata[CODE_W-1:0] = dat_q[dat_idx];
        end
    end

    assign cmd    = cmd_q;
    assign lo_cnt = div_q[PH_W-1:0];
    assign hi_cnt = div_q[DIV_W-1:PH_W];
    assign irq    = irq_q;

    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(store));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_res) |=> irq);

    p_start_clear_r10: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> !cmd.start);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              adc_clk,
    output logic              fe_req,
    output logic [CH_W-1:0]   fe_chan,
    output logic              fe_vref_int,
    input  logic              fe_valid,
    input  logic [CODE_W-1:0] fe_code,
    output logic              irq
);

    cmd_t            cfg;
    logic [PH_W-1:0] lo_cnt;
    logic [PH_W-1:0] hi_cnt;
    logic            launch;
    logic            busy;
    logic            store;
    logic            rise_next;
    result_t         result;

    adc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .store     (store),
        .result    (result),
        .cmd       (cfg),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .launch    (launch),
        .irq       (irq)
    );

    adc_clk_gen #(.P_W(PH_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.enable),
        .lo_cnt    (lo_cnt),
        .hi_cnt    (hi_cnt),
        .adc_clk   (adc_clk),
        .rise_next (rise_next)
    );

    adc_avg_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.enable),
        .launch    (launch),
        .chan_in   (bus_wdata[CH_W:1]),
        .avg_in    (bus_wdata[CH_W+1+AVG_W:CH_W+2]),
        .edge_rise (rise_next),
        .adc_clk   (adc_clk),
        .fe_valid  (fe_valid),
        .fe_code   (fe_code),
        .fe_req    (fe_req),
        .cur_chan  (fe_chan),
        .busy      (busy),
        .store     (store),
        .result    (result)
    );

    assign fe_vref_int = cfg.int_ref;

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    import adc_seq_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              adc_clk, fe_req, fe_vref_int, fe_valid, irq;
    logic [CH_W-1:0]   fe_chan;
    logic [CODE_W-1:0] fe_code;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_clk(adc_clk), .fe_req(fe_req), .fe_chan(fe_chan),
        .fe_vref_int(fe_vref_int), .fe_valid(fe_valid), .fe_code(fe_code),
        .irq(irq)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;
    int          req_cnt, samp_cnt, chan_err;
    longint      sum;
    logic [2:0]  exp_chan;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit st, input int ch, input bit en,
                                           input int avg, input bit iref);
        return {22'd0, iref, 4'(avg), en, 3'(ch), st};
    endfunction

    function automatic int eff_len(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    task automatic clear_counts();
        req_cnt = 0; samp_cnt = 0; chan_err = 0; sum = 0;
    endtask

    // Front-end model: one valid strobe per request after 0..3 cycles.
    initial begin
        fe_valid = 1'b0;
        fe_code  = '0;
        clear_counts();
        forever begin
            @(negedge clk);
            if (fe_req === 1'b1) begin
                req_cnt++;
                if (fe_chan !== exp_chan) chan_err++;
                repeat ($urandom % 4) @(negedge clk);
                fe_code  = 10'($urandom % 1024);
                fe_valid = 1'b1;
                sum      = sum + longint'(fe_code);
                samp_cnt++;
                @(negedge clk);
                fe_valid = 1'b0;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (irq === 1'b1) break;
        end
    endtask

    task automatic run_conv(input int ch, input int n, input int lo, input int hi, input bit iref);
        logic [31:0] d;
        longint exp_val;
        clear_counts();
        exp_chan = 3'(ch);
        wr(1, {24'd0, 4'(hi), 4'(lo)});
        wr(0, mk_cmd(1, ch, 1, n, iref));
        check(fe_vref_int == iref, "R2 reference select", fe_vref_int, iref);
        wait_irq(20000);
        check(irq === 1'b1, "R8 interrupt raised", irq, 1);
        repeat (5) @(negedge clk);
        check(irq === 1'b1, "R8 interrupt held", irq, 1);
        check(samp_cnt == (1 << n), n == 0 ? "R5 single sample" : "R6 sample count", samp_cnt, 1 << n);
        check(chan_err == 0, "R2 channel on requests", chan_err, 0);
        exp_val = sum >> n;
        rd(2, d);
        check(longint'(d[9:0]) == exp_val, n == 0 ? "R5 result" : "R6 averaged result", d[9:0], exp_val);
        check(d[31:10] == 0, "R7 upper bits zero", d[31:10], 0);
        check(irq === 1'b0, "R8 cleared by read", irq, 0);
        rd(16 + ch, d);
        check(longint'(d) == exp_val, "R7 channel data", d, exp_val);
    endtask

    task automatic measure_clk(input int lo, input int hi);
        int lo_seen, hi_seen;
        wr(1, {24'd0, 4'(hi), 4'(lo)});
        wr(0, mk_cmd(0, 0, 1, 0, 0));
        for (int i = 0; i < 100 && adc_clk !== 1'b1; i++) @(negedge clk);
        for (int i = 0; i < 100 && adc_clk !== 1'b0; i++) @(negedge clk);
        lo_seen = 0;
        while (adc_clk === 1'b0 && lo_seen < 100) begin lo_seen++; @(negedge clk); end
        hi_seen = 0;
        while (adc_clk === 1'b1 && hi_seen < 100) begin hi_seen++; @(negedge clk); end
        check(lo_seen == eff_len(lo), lo == 0 ? "R4 zero low count" : "R3 low phase", lo_seen, eff_len(lo));
        check(hi_seen == eff_len(hi), hi == 0 ? "R4 zero high count" : "R3 high phase", hi_seen, eff_len(hi));
        wr(0, 32'd0);
        repeat (3) @(negedge clk);
        check(adc_clk === 1'b0, "R3 low when disabled", adc_clk, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int snap;
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        exp_chan = '0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(irq === 1'b0, "R1 irq after reset", irq, 0);
        check(adc_clk === 1'b0, "R1 clock after reset", adc_clk, 0);
        check(fe_req === 1'b0, "R1 request after reset", fe_req, 0);
        rd(0, d); check(d == 0, "R1 command reg", d, 0);
        rd(1, d); check(d == 0, "R1 divider reg", d, 0);
        rd(2, d); check(d == 0, "R1 result reg", d, 0);

        // R10 field readback
        wr(0, mk_cmd(0, 5, 1, 3, 1));
        rd(0, d); check(d == mk_cmd(0, 5, 1, 3, 1), "R10 command readback", d, mk_cmd(0, 5, 1, 3, 1));
        wr(0, 32'd0);

        // R12 control registers
        for (int i = 0; i < 8; i++) wr(8 + i, 32'hA500_0000 + 32'(i * 17));
        for (int i = 0; i < 8; i++) begin
            rd(8 + i, d);
            check(d == 32'hA500_0000 + 32'(i * 17), "R12 control readback", d, 32'hA500_0000 + 32'(i * 17));
        end

        // R3 / R4 clock phases
        measure_clk(3, 5);
        measure_clk(1, 1);
        measure_clk(0, 0);
        measure_clk(0, 7);
        measure_clk(15, 2);

        // Directed conversions
        run_conv(0, 0, 0, 0, 0);
        run_conv(7, 3, 2, 3, 1);

        // Random conversions
        for (int it = 0; it < 20; it++) begin
            run_conv($urandom % 8, $urandom % 4, $urandom % 16, $urandom % 16, 1'($urandom % 2));
        end

        // R9 start with enable clear
        clear_counts();
        wr(0, mk_cmd(1, 2, 0, 0, 0));
        repeat (100) @(negedge clk);
        check(req_cnt == 0, "R9 disabled start no request", req_cnt, 0);
        check(irq === 1'b0, "R9 disabled start no irq", irq, 0);
        rd(0, d); check(d == mk_cmd(0, 2, 0, 0, 0), "R10 start reads zero", d, mk_cmd(0, 2, 0, 0, 0));

        // R9 start while busy
        clear_counts();
        exp_chan = 3'd1;
        wr(1, {24'd0, 4'd6, 4'd6});
        wr(0, mk_cmd(1, 1, 1, 2, 0));
        repeat (20) @(negedge clk);
        wr(0, mk_cmd(1, 6, 1, 0, 0));
        wait_irq(20000);
        check(samp_cnt == 4, "R9 busy start no extra samples", samp_cnt, 4);
        check(chan_err == 0, "R9 busy start channel kept", chan_err, 0);
        rd(2, d); check(longint'(d) == (sum >> 2), "R9 busy start result", d, sum >> 2);
        rd(0, d); check(d == mk_cmd(0, 6, 1, 0, 0), "R10 fields after busy write", d, mk_cmd(0, 6, 1, 0, 0));

        // R12 abort
        clear_counts();
        exp_chan = 3'd3;
        wr(0, mk_cmd(1, 3, 1, 3, 0));
        for (int i = 0; i < 2000 && samp_cnt < 1; i++) @(negedge clk);
        wr(0, 32'd0);
        repeat (10) @(negedge clk);
        snap = req_cnt;
        repeat (200) @(negedge clk);
        check(irq === 1'b0, "R12 abort no irq", irq, 0);
        check(adc_clk === 1'b0, "R12 abort clock low", adc_clk, 0);
        check(req_cnt == snap, "R12 abort no requests", req_cnt, snap);
        check(samp_cnt < 8, "R12 abort sequence cut short", samp_cnt, 1);
        run_conv(3, 1, 1, 1, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule